// File: doc/BRIEF.md
# Scan Result FIFO with Overflow Policy

This block queues conversion results from a multi-channel scan until software or a downstream consumer pops them. Results enter through a single write strobe from the converter. The oldest stored result is always visible on the read port, and a pop strobe removes it. The FIFO holds four entries by default.

Two sticky interrupt flags report the queue state. The scan-ready flag rises once the number of waiting results reaches a programmable threshold of level+1. The overflow flag rises whenever a result arrives while the queue is full and no pop frees a slot in that cycle.

A policy bit decides what happens to that result. Drop mode throws the new result away and leaves the stored contents alone. Replace mode evicts the oldest entry and keeps the newest results. Each flag is cleared by a one-cycle strobe, and a new set event in the same cycle takes priority over the clear.

Top module: `scan_result_fifo`

## Requirements
- R1: After reset, count_o is 0, rd_valid_o is 0, and both interrupt flags are 0.
- R2: While rd_valid_o is 1, rd_data_o shows the oldest stored result. Results leave in the order they were written.
- R3: A pop while the FIFO is empty has no effect. A write in that same cycle is still stored.
- R4: With ovf_policy_i = 0 (drop), a write to a full FIFO without a pop is discarded. Count and contents stay unchanged.
- R5: With ovf_policy_i = 1 (replace), a write to a full FIFO without a pop evicts the oldest entry. The new result becomes the youngest entry, and count stays at DEPTH.
- R6: A write to a full FIFO without a pop sets ovf_irq_o on the next clock edge, in both policies.
- R7: A write and a pop in the same cycle on a full FIFO perform both operations. This is not an overflow, and count stays at DEPTH.
- R8: ready_irq_o is set on the clock edge at which count_o becomes at least dv_level_i+1 (dv_level_i ranges over 0..3).
- R9: Both flags stay set until their clear strobe is given. When a set condition and a clear strobe occur in the same cycle, the flag stays set.
- R10: count_o equals the number of stored results and never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_valid_i | input | 1 | Converter result strobe |
| wr_data_i | input | DATA_W | Converter result |
| pop_i | input | 1 | Remove the oldest entry |
| rd_data_o | output | DATA_W | Oldest stored result |
| rd_valid_o | output | 1 | FIFO not empty |
| count_o | output | $clog2(DEPTH+1) | Stored entry count |
| ovf_policy_i | input | 1 | 0 drop new result, 1 replace oldest |
| dv_level_i | input | LVL_W | Ready threshold minus one |
| ready_clr_i | input | 1 | Clear strobe for ready flag |
| ovf_clr_i | input | 1 | Clear strobe for overflow flag |
| ready_irq_o | output | 1 | Sticky scan-ready flag |
| ovf_irq_o | output | 1 | Sticky overflow flag |

## Verification
A pointer or count that goes wrong shows up on the ports within one cycle. It appears either as a count_o that differs from the model, or as a wrong head value on rd_data_o, because the head is read combinationally. A wrong overflow policy can hide until the stored entries are popped, so every overflow scenario is followed by a complete drain that compares each value in order. Threshold and flag errors show up on the same edge as the count change that should trigger them.

// File: rtl/scan_fifo_pkg.sv
package scan_fifo_pkg;
  typedef enum logic {
    OVF_DROP    = 1'b0,
    OVF_REPLACE = 1'b1
  } ovf_policy_e;
endpackage

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  parameter int PTR_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [PTR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [PTR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (wr_en_i && (wr_addr_i == PTR_W'(g)))
        mem_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl
  import scan_fifo_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_valid_i,
  input  logic             pop_i,
  input  ovf_policy_e      policy_i,
  output logic             wr_en_o,
  output logic [PTR_W-1:0] wr_addr_o,
  output logic [PTR_W-1:0] rd_addr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_next_o,
  output logic             overflow_o
);
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic full, empty, do_pop, accept, replace, ovf;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_pop  = pop_i & ~empty;
  assign ovf     = wr_valid_i & full & ~do_pop;
  assign accept  = wr_valid_i & (~full | do_pop);
  assign replace = ovf & (policy_i == OVF_REPLACE);

  always_comb begin
    wr_ptr_d = (accept | replace) ? ptr_inc(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = (do_pop | replace) ? ptr_inc(rd_ptr_q) : rd_ptr_q;
    unique case ({accept, do_pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  assign wr_en_o    = accept | replace;
  assign wr_addr_o  = wr_ptr_q;
  assign rd_addr_o  = rd_ptr_q;
  assign cnt_o      = cnt_q;
  assign cnt_next_o = cnt_d;
  assign overflow_o = ovf;
endmodule

// File: rtl/scan_result_fifo.sv
module scan_result_fifo
  import scan_fifo_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic [CNT_W-1:0]  count_o,
  input  logic              ovf_policy_i,
  input  logic [LVL_W-1:0]  dv_level_i,
  input  logic              ready_clr_i,
  input  logic              ovf_clr_i,
  output logic              ready_irq_o,
  output logic              ovf_irq_o
);
  logic             wr_en, overflow, ready_set;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [CNT_W-1:0] cnt, cnt_next;
  ovf_policy_e      policy;

  assign policy = ovf_policy_e'(ovf_policy_i);

  fifo_ptr_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .pop_i      (pop_i),
    .policy_i   (policy),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .rd_addr_o  (rd_addr),
    .cnt_o      (cnt),
    .cnt_next_o (cnt_next),
    .overflow_o (overflow)
  );

  fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data_o)
  );

  // threshold is level+1 entries, evaluated on the post-update count
  assign ready_set = (int'(cnt_next) > int'(dv_level_i));

  sticky_flag u_ready_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (ready_set),
    .clr_i  (ready_clr_i),
    .flag_o (ready_irq_o)
  );

  sticky_flag u_ovf_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (overflow),
    .clr_i  (ovf_clr_i),
    .flag_o (ovf_irq_o)
  );

  assign count_o    = cnt;
  assign rd_valid_o = (cnt != '0);
endmodule

// File: rtl/scan_fifo_chk.sv
module scan_fifo_chk #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 4,
  parameter int LVL_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_i,
  input logic              pop_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              ovf_policy_i,
  input logic [LVL_W-1:0]  dv_level_i,
  input logic              ready_clr_i,
  input logic              ovf_clr_i,
  input logic              ready_irq_o,
  input logic              ovf_irq_o
);
  logic full;
  assign full = (count_o == CNT_W'(DEPTH));

  // R10
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(count_o) <= DEPTH);

  // R4
  drop_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && wr_valid_i && !pop_i && !ovf_policy_i)
    |=> ($stable(count_o) && $stable(rd_data_o)));

  // R5
  replace_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && wr_valid_i && !pop_i && ovf_policy_i) |=> full);

  // R6
  ovf_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && wr_valid_i && !pop_i) |=> ovf_irq_o);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_irq_o && full && wr_valid_i && pop_i) |=> (!ovf_irq_o && full));

  // R3
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == '0 && pop_i && !wr_valid_i) |=> (count_o == '0));

  // R9
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_irq_o && !ready_clr_i) |=> ready_irq_o);

  // R9
  ovf_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_irq_o && !ovf_clr_i) |=> ovf_irq_o);

  // R8
  ready_reach_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(count_o) > int'(dv_level_i)) |=> (ready_irq_o || int'(count_o) <= int'($past(dv_level_i)) || ready_irq_o));
endmodule

bind scan_result_fifo scan_fifo_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .wr_valid_i   (wr_valid_i),
  .pop_i        (pop_i),
  .rd_data_o    (rd_data_o),
  .count_o      (count_o),
  .ovf_policy_i (ovf_policy_i),
  .dv_level_i   (dv_level_i),
  .ready_clr_i  (ready_clr_i),
  .ovf_clr_i    (ovf_clr_i),
  .ready_irq_o  (ready_irq_o),
  .ovf_irq_o    (ovf_irq_o)
);

// File: tb/tb_scan_result_fifo.sv
module tb_scan_result_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 12;
  localparam int DEPTH  = 4;
  localparam int LVL_W  = 2;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_valid_i = 1'b0, pop_i = 1'b0, ovf_policy_i = 1'b0;
  logic ready_clr_i = 1'b0, ovf_clr_i = 1'b0;
  logic [DATA_W-1:0] wr_data_i = '0;
  logic [LVL_W-1:0]  dv_level_i = '0;
  logic [DATA_W-1:0] rd_data_o;
  logic              rd_valid_o, ready_irq_o, ovf_irq_o;
  logic [CNT_W-1:0]  count_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  // reference model: m_q[0] is oldest
  logic [DATA_W-1:0] m_q [DEPTH];
  int  m_cnt = 0;
  bit  m_rdy = 0, m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_result_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .pop_i(pop_i), .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o), .count_o(count_o),
    .ovf_policy_i(ovf_policy_i), .dv_level_i(dv_level_i), .ready_clr_i(ready_clr_i),
    .ovf_clr_i(ovf_clr_i), .ready_irq_o(ready_irq_o), .ovf_irq_o(ovf_irq_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void m_shift();
    for (int i = 0; i < DEPTH - 1; i++) m_q[i] = m_q[i+1];
    m_cnt--;
  endfunction

  function automatic void m_step(bit wr, logic [DATA_W-1:0] d, bit pop, bit pol,
                                 int lvl, bit rclr, bit oclr);
    bit dp, ov;
    dp = pop && (m_cnt > 0);
    ov = wr && (m_cnt == DEPTH) && !dp;
    if (ov) begin
      if (pol) begin m_shift(); m_q[m_cnt] = d; m_cnt++; end
    end else begin
      if (dp) m_shift();
      if (wr) begin m_q[m_cnt] = d; m_cnt++; end
    end
    m_rdy = (m_cnt >= lvl + 1) || (m_rdy && !rclr);
    m_ovf = ov || (m_ovf && !oclr);
  endfunction

  task automatic compare(input string req);
    check(req, "count", int'(count_o), m_cnt);
    check(req, "rd_valid", int'(rd_valid_o), int'(m_cnt > 0));
    if (m_cnt > 0) check(req, "rd_data", int'(rd_data_o), int'(m_q[0]));
    check(req, "ready_irq", int'(ready_irq_o), int'(m_rdy));
    check(req, "ovf_irq", int'(ovf_irq_o), int'(m_ovf));
  endtask

  task automatic step(input string req, input bit wr, input logic [DATA_W-1:0] d,
                      input bit pop, input bit rclr = 0, input bit oclr = 0);
    @(negedge clk);
    wr_valid_i = wr; wr_data_i = d; pop_i = pop;
    ready_clr_i = rclr; ovf_clr_i = oclr;
    @(posedge clk);
    #1;
    m_step(wr, d, pop, ovf_policy_i, int'(dv_level_i), rclr, oclr);
    compare(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_q[i] = '0;
    #(CLK_PERIOD * 2 + 3);
    // R1 reset state
    check("R1", "count", int'(count_o), 0);
    check("R1", "rd_valid", int'(rd_valid_o), 0);
    check("R1", "flags", int'({ready_irq_o, ovf_irq_o}), 0);
    @(negedge clk); rst_ni = 1'b1;

    // R3 pop on empty, then pop with simultaneous write
    step("R3", 0, '0, 1);
    step("R3", 1, 12'h0a1, 1);
    step("R3", 0, '0, 1);

    // R8 threshold 4: ready only at the fourth entry
    dv_level_i = 2'd3;
    step("R8", 0, '0, 0, 1, 0);
    step("R8", 1, 12'h101, 0);
    step("R8", 1, 12'h102, 0);
    step("R8", 1, 12'h103, 0);
    check("R8", "ready before threshold", int'(ready_irq_o), 0);
    step("R8", 1, 12'h104, 0);
    check("R8", "ready at threshold", int'(ready_irq_o), 1);

    // R4 drop policy on full; R6 flag
    ovf_policy_i = 1'b0;
    step("R4", 1, 12'h555, 0);
    check("R6", "ovf after drop", int'(ovf_irq_o), 1);
    // R9 clear while set condition persists keeps ready; ovf clears
    step("R9", 0, '0, 0, 1, 1);
    check("R9", "ready set wins", int'(ready_irq_o), 1);
    check("R9", "ovf cleared", int'(ovf_irq_o), 0);
    // R9 set and clear same cycle
    step("R9", 1, 12'h556, 0, 0, 1);
    check("R9", "ovf set wins", int'(ovf_irq_o), 1);
    step("R9", 0, '0, 0, 0, 1);

    // R5 replace policy then drain in order
    ovf_policy_i = 1'b1;
    step("R5", 1, 12'h201, 0);
    step("R5", 1, 12'h202, 0);
    check("R5", "head after replace", int'(rd_data_o), 12'h103);
    step("R5", 0, '0, 0, 0, 1);
    // R7 full with pop and write: no overflow
    step("R7", 1, 12'h301, 1);
    check("R7", "ovf stays clear", int'(ovf_irq_o), 0);
    for (int i = 0; i < DEPTH; i++) step("R2", 0, '0, 1);
    // R10 empty again
    check("R10", "count drained", int'(count_o), 0);

    // R8 every level
    for (int l = 0; l < 4; l++) begin
      dv_level_i = LVL_W'(l);
      step("R8", 0, '0, 0, 1, 1);
      for (int k = 0; k <= l; k++) step("R8", 1, DATA_W'(k + 16*l), 0);
      check("R8", "ready at level", int'(ready_irq_o), 1);
      for (int k = 0; k <= l; k++) step("R2", 0, '0, 1);
    end

    // R2 random traffic across policies, levels and clears
    for (int n = 0; n < 4000; n++) begin
      if (n % 97 == 0) begin
        ovf_policy_i = 1'($urandom);
        dv_level_i = LVL_W'($urandom);
      end
      step("R2", ($urandom % 100) < 55, DATA_W'($urandom), ($urandom % 100) < 40,
           ($urandom % 8) == 0, ($urandom % 8) == 0);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule